// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

The block holds two 8-bit interval timers, a low timer and a high timer, behind a byte-wide register bus. Each timer divides the system clock with its own prescaler, counts the prescaled ticks, and compares the count with a data register. When the count equals the data value on a tick, the timer sets its interrupt flag and restarts from zero. A data value of N therefore gives an interval of N+1 ticks. Each timer drives a level interrupt output, which is high while both its flag and its enable are set.

Setting the high timer's clock-select field to its fourth code joins the pair into one 16-bit timer. The low timer supplies the base rate and forms the lower byte. The high timer forms the upper byte and advances when the lower byte wraps. The match is taken on the two data registers together, and only the high timer's flag and enable take part.

Software controls each timer through a separate start bit and stop bit. A rising start bit clears the count and begins counting. Clearing the start bit ends counting. The stop bit pauses counting and keeps the count.

Top module: `cascade_interval_timer`

## Requirements
- R1: Four byte registers sit at BASE_ADDR plus 0 (high control), 1 (low control), 2 (high data) and 3 (low data); BASE_ADDR defaults to 0x18. The data registers read back what was last written.
- R2: After reset both control registers read 0x00 and both interrupt outputs are low.
- R3: A control byte holds these fields: bit 7 is the flag, bit 6 the enable, bits 3..2 the clock select, bit 1 the stop bit and bit 0 the start bit. Bits 5..4 always read 0 and ignore writes. Writing a 1 to bit 7 cannot set the flag.
- R4: A write that takes the start bit from 0 to 1 clears the count and the prescaler, and counting begins. While the start bit is 0 the timer does not count and raises no flag. A new start always measures a full interval.
- R5: While the stop bit is 1 the count and the prescaler hold their values. Clearing the stop bit resumes counting without clearing, so the interval grows by exactly the number of stopped cycles.
- R6: Clock-select code 00 gives one count per 2 clocks, code 01 one count per 4 clocks and code 10 one count per 8 clocks. On a timer running alone, code 11 behaves as code 10.
- R7: With data N and a period of D clocks per count, the flag is set on the clock edge N+1 counts, that is (N+1)*D clocks, after the starting write. The count then restarts, so the next match comes after the same interval.
- R8: Writing a control byte with bit 7 at 0 clears the flag. Writing it with bit 7 at 1 leaves the flag unchanged.
- R9: If a write that clears the flag and a new match fall on the same edge, the flag stays set.
- R10: Each interrupt output is high exactly when its timer's flag and enable bits are both 1. A set flag with the enable at 0 keeps the output low.
- R11: When the high timer's clock select is 11, the pair counts as one 16-bit value at the low timer's rate. The high flag is set after ({high data, low data}+1)*D clocks, and the low flag is never set in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_lo | output | 1 | Low timer interrupt request (level) |
| irq_hi | output | 1 | High timer interrupt request (level) |

## Verification
The bench builds the block with its default parameters. BASE_ADDR is 0x18 and PRE_W is 3, which gives clock dividers of 2, 4 and 8. With these values, 16-bit cascade intervals of a few hundred counts take only a few thousand clocks, so the bench can measure the carry from the lower byte into the upper byte and the combined match exactly. The 8-bit intervals run up to the full data value of 255, and the bench can place a flag-clearing write on the very edge of a match when the interval is 2 clocks.

// File: rtl/cit_pkg.sv
package cit_pkg;

   // control field positions inside the control byte
   localparam int unsigned B_FLAG = 7;
   localparam int unsigned B_IE   = 6;
   localparam int unsigned B_CSH  = 3;
   localparam int unsigned B_CSL  = 2;
   localparam int unsigned B_STP  = 1;
   localparam int unsigned B_STR  = 0;

   localparam logic [1:0] CS_JOIN = 2'b11;

   typedef struct packed {
      logic       flag;
      logic       ie;
      logic [1:0] cs;
      logic       stp;
      logic       str;
   } ctrl_t;

   function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
      return {c.flag, c.ie, 2'b00, c.cs, c.stp, c.str};
   endfunction

endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler #(
   parameter int unsigned PRE_W = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   localparam logic [PRE_W-1:0] LIM0 = PRE_W'((32'd1 << (PRE_W - 2)) - 32'd1);
   localparam logic [PRE_W-1:0] LIM1 = PRE_W'((32'd1 << (PRE_W - 1)) - 32'd1);
   localparam logic [PRE_W-1:0] LIM2 = {PRE_W{1'b1}};

   generate
      if (PRE_W < 3) begin : g_bad_pre
         $error("cit_prescaler: PRE_W must be at least 3");
      end
   endgenerate

   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] lim;

   always_comb begin
      unique case (sel)
         2'b00:   lim = LIM0;
         2'b01:   lim = LIM1;
         default: lim = LIM2;
      endcase
   end

   assign tick = run & (pre >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre <= '0;
      end else if (clr) begin
         pre <= '0;
      end else if (run) begin
         pre <= (pre >= lim) ? '0 : pre + 1'b1;
      end
   end

   p_pre_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(pre));
   p_pre_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre == '0));

endmodule

// File: rtl/cit_count_unit.sv
module cit_count_unit #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             match,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max
);
   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("cit_count_unit: CNT_W must be at least 2");
      end
   endgenerate

   assign at_max = (cnt == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= match ? '0 : cnt + 1'b1;
      end
   end

   p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && match && !clr) |=> (cnt == '0));
   p_cnt_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(cnt));

endmodule

// File: rtl/cit_ctrl_reg.sv
module cit_ctrl_reg
   import cit_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       w_flag,
   input  logic       w_ie,
   input  logic [1:0] w_cs,
   input  logic       w_stp,
   input  logic       w_str,
   input  logic       set_flag,
   output ctrl_t      q,
   output logic       start
);
   assign start = wr & w_str & ~q.str;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr) begin
            q.ie  <= w_ie;
            q.cs  <= w_cs;
            q.stp <= w_stp;
            q.str <= w_str;
         end
         if (set_flag) begin
            q.flag <= 1'b1;
         end else if (wr && !w_flag) begin
            q.flag <= 1'b0;
         end
      end
   end

   p_flag_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_flag |=> q.flag);
   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q.flag && !(wr && !w_flag)) |=> q.flag);
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !w_flag && !set_flag) |=> !q.flag);
   p_flag_no_write_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!q.flag && !set_flag) |=> !q.flag);

endmodule

// File: rtl/cascade_interval_timer.sv
module cascade_interval_timer
   import cit_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('h18),
   parameter int unsigned       PRE_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_lo,
   output logic              irq_hi
);
   localparam int unsigned CNT_W  = 8;
   localparam int unsigned N_UNIT = 2;
   localparam int unsigned LO     = 0;
   localparam int unsigned HI     = 1;

   generate
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("cascade_interval_timer: ADDR_W must be at least 3");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("cascade_interval_timer: BASE_ADDR must be 4-byte aligned");
      end
   endgenerate

   ctrl_t             ctl     [N_UNIT];
   logic [CNT_W-1:0]  cnt     [N_UNIT];
   logic [CNT_W-1:0]  dat     [N_UNIT];
   logic [N_UNIT-1:0] tick, step, match, setf, startp, wr_ctl, wr_dat, at_max;
   logic              hit, joined, match_all;

   assign hit       = (bus_addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
   assign joined    = (ctl[HI].cs == CS_JOIN);
   assign match_all = ({cnt[HI], cnt[LO]} == {dat[HI], dat[LO]});

   // per-timer sequencing: the low timer never looks at the join
   // except to suppress its own flag and to use the joint compare
   assign step[LO]  = tick[LO];
   assign match[LO] = joined ? match_all : (cnt[LO] == dat[LO]);
   assign setf[LO]  = tick[LO] & match[LO] & ~joined;

   assign step[HI]  = joined ? (tick[LO] & (match_all | at_max[LO])) : tick[HI];
   assign match[HI] = joined ? match_all : (cnt[HI] == dat[HI]);
   assign setf[HI]  = joined ? (tick[LO] & match_all) : (tick[HI] & match[HI]);

   for (genvar i = 0; i < N_UNIT; i++) begin : g_unit
      localparam logic [1:0] CTL_OFS = (i == HI) ? 2'd0 : 2'd1;
      localparam logic [1:0] DAT_OFS = (i == HI) ? 2'd2 : 2'd3;

      assign wr_ctl[i] = bus_wr & hit & (bus_addr[1:0] == CTL_OFS);
      assign wr_dat[i] = bus_wr & hit & (bus_addr[1:0] == DAT_OFS);

      cit_ctrl_reg u_ctrl (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_ctl[i]),
         .w_flag   (bus_wdata[B_FLAG]),
         .w_ie     (bus_wdata[B_IE]),
         .w_cs     (bus_wdata[B_CSH:B_CSL]),
         .w_stp    (bus_wdata[B_STP]),
         .w_str    (bus_wdata[B_STR]),
         .set_flag (setf[i]),
         .q        (ctl[i]),
         .start    (startp[i])
      );

      cit_prescaler #(.PRE_W(PRE_W)) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (startp[i]),
         .run   (ctl[i].str & ~ctl[i].stp),
         .sel   (ctl[i].cs),
         .tick  (tick[i])
      );

      cit_count_unit #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (startp[i]),
         .step   (step[i]),
         .match  (match[i]),
         .cnt    (cnt[i]),
         .at_max (at_max[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dat[i] <= '0;
         end else if (wr_dat[i]) begin
            dat[i] <= bus_wdata;
         end
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (hit) begin
         unique case (bus_addr[1:0])
            2'd0:    bus_rdata = ctrl_to_byte(ctl[HI]);
            2'd1:    bus_rdata = ctrl_to_byte(ctl[LO]);
            2'd2:    bus_rdata = dat[HI];
            default: bus_rdata = dat[LO];
         endcase
      end
   end

   assign irq_lo = ctl[LO].flag & ctl[LO].ie;
   assign irq_hi = ctl[HI].flag & ctl[HI].ie;

   logic unused_bits;
   assign unused_bits = ^{bus_wdata[5:4], at_max[HI]};

   p_lo_quiet_joined_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (joined && !ctl[LO].flag) |=> !ctl[LO].flag);
   p_joint_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (joined && tick[LO] && at_max[LO] && !match_all && !startp[LO] && !startp[HI])
      |=> (cnt[LO] == '0));
   p_idle_no_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[LO].str && !joined && !ctl[LO].flag) |=> !ctl[LO].flag);

endmodule

// File: tb/sim_cascade_interval_timer.sv
module sim_cascade_interval_timer;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CHI = 8'h18;
   localparam logic [7:0] A_CLO = 8'h19;
   localparam logic [7:0] A_DHI = 8'h1A;
   localparam logic [7:0] A_DLO = 8'h1B;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_lo, irq_hi;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int t0 = 0;

   cascade_interval_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int period(input int n, input int cs);
      int div;
      div = (cs >= 2) ? 8 : ((cs == 1) ? 4 : 2);
      return (n + 1) * div;
   endfunction

   function automatic logic [7:0] ctl_byte(input bit ie, input int cs, input bit stp, input bit str);
      return {1'b0, ie, 2'b00, 2'(cs), stp, str};
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_irq(input bit hi, output int d);
      int k;
      k = 0;
      while (((hi ? irq_hi : irq_lo) !== 1'b1) && k < 20000) begin
         @(negedge clk);
         k++;
      end
      d = (k >= 20000) ? -1 : (cyc - t0);
   endtask

   task automatic run_single(input bit hi, input int n, input int cs, input string tag);
      logic [7:0] ca, da;
      int d;
      ca = hi ? A_CHI : A_CLO;
      da = hi ? A_DHI : A_DLO;
      wr(ca, 8'h00);
      wr(da, 8'(n));
      wr(ca, ctl_byte(1'b1, cs, 1'b0, 1'b1));
      t0 = cyc;
      wait_irq(hi, d);
      check({tag, " R7 first interval"}, d, period(n, cs));
      wr(ca, ctl_byte(1'b1, cs, 1'b0, 1'b1));
      wait_irq(hi, d);
      check({tag, " R7 restart interval"}, d, 2 * period(n, cs));
      wr(ca, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int d, ts, tu;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      check("R2 irq_lo", int'(irq_lo), 0);
      check("R2 irq_hi", int'(irq_hi), 0);
      rd(A_CHI, r); check("R2 high control", int'(r), 0);
      rd(A_CLO, r); check("R2 low control", int'(r), 0);

      // R1 data read-back
      wr(A_DHI, 8'hA5); wr(A_DLO, 8'h3C);
      rd(A_DHI, r); check("R1 high data", int'(r), 'hA5);
      rd(A_DLO, r); check("R1 low data", int'(r), 'h3C);

      // R3 reserved bits and flag not writable as 1
      wr(A_CLO, 8'hB8);
      rd(A_CLO, r); check("R3 reserved/flag", int'(r), 'h08);
      wr(A_CLO, 8'h00);

      // R6/R7 directed intervals
      run_single(1'b0, 5, 0, "R6 low cs00");
      run_single(1'b1, 3, 1, "R6 high cs01");
      run_single(1'b0, 0, 2, "R6 low cs10");
      run_single(1'b0, 2, 3, "R6 low cs11 alone");
      run_single(1'b1, 255, 0, "R7 high max data");

      // R8 flag write 1 keeps, write 0 clears
      wr(A_CLO, 8'h00); wr(A_DLO, 8'd50);
      wr(A_CLO, ctl_byte(1'b1, 2, 1'b0, 1'b1));
      t0 = cyc;
      wait_irq(1'b0, d);
      wr(A_CLO, 8'h80 | ctl_byte(1'b1, 2, 1'b0, 1'b1));
      rd(A_CLO, r); check("R8 write 1 keeps flag", int'(r[7]), 1);
      check("R8 irq still high", int'(irq_lo), 1);
      wr(A_CLO, ctl_byte(1'b1, 2, 1'b0, 1'b1));
      rd(A_CLO, r); check("R8 write 0 clears flag", int'(r[7]), 0);
      check("R10 irq follows flag", int'(irq_lo), 0);
      wr(A_CLO, 8'h00);

      // R10 enable off
      wr(A_CHI, 8'h00); wr(A_DHI, 8'd4);
      wr(A_CHI, ctl_byte(1'b0, 0, 1'b0, 1'b1));
      repeat (period(4, 0) + 2) @(negedge clk);
      check("R10 irq masked", int'(irq_hi), 0);
      rd(A_CHI, r); check("R10 flag set while masked", int'(r[7]), 1);
      wr(A_CHI, 8'h00);

      // R4 terminate then restart
      wr(A_CLO, 8'h00); wr(A_DLO, 8'd3);
      wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b1));
      repeat (2) @(negedge clk);
      wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
      check("R4 terminated irq", int'(irq_lo), 0);
      rd(A_CLO, r); check("R4 terminated flag", int'(r[7]), 0);
      wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b1));
      t0 = cyc;
      wait_irq(1'b0, d);
      check("R4 restart full interval", d, period(3, 0));
      wr(A_CLO, 8'h00);

      // R5 stop holds
      wr(A_DLO, 8'd20);
      wr(A_CLO, ctl_byte(1'b1, 1, 1'b0, 1'b1));
      t0 = cyc;
      repeat (10) @(negedge clk);
      wr(A_CLO, ctl_byte(1'b1, 1, 1'b1, 1'b1));
      ts = cyc;
      repeat (17) @(negedge clk);
      check("R5 no irq while stopped", int'(irq_lo), 0);
      wr(A_CLO, ctl_byte(1'b1, 1, 1'b0, 1'b1));
      tu = cyc;
      wait_irq(1'b0, d);
      check("R5 stretched interval", d, period(20, 1) + (tu - ts));
      wr(A_CLO, 8'h00);

      // R9 clear against match on the same edge
      wr(A_DLO, 8'd0);
      wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b1));
      t0 = cyc;
      wait_irq(1'b0, d);
      if (((cyc - t0) % 2) != 0) @(negedge clk);
      wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b1));
      rd(A_CLO, r); check("R9 clear off the match edge", int'(r[7]), 0);
      wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b1));
      rd(A_CLO, r); check("R9 match wins over clear", int'(r[7]), 1);
      wr(A_CLO, 8'h00);

      // R11 joined 16-bit mode
      wr(A_CHI, 8'h00);
      wr(A_DHI, 8'd1); wr(A_DLO, 8'd3);
      wr(A_CHI, ctl_byte(1'b1, 3, 1'b0, 1'b1));
      wr(A_CLO, ctl_byte(1'b0, 0, 1'b0, 1'b1));
      t0 = cyc;
      wait_irq(1'b1, d);
      check("R11 joined interval", d, period(259, 0));
      rd(A_CLO, r); check("R11 low flag stays clear", int'(r[7]), 0);
      wr(A_CLO, 8'h00); wr(A_CHI, 8'h00);

      // constrained random intervals
      for (int it = 0; it < 16; it++) begin
         run_single(1'($urandom % 2), int'($urandom % 24), int'($urandom % 3), "R7 random");
      end
      for (int it = 0; it < 3; it++) begin
         int nh, nl;
         nh = int'($urandom % 2);
         nl = int'($urandom % 256);
         wr(A_CHI, 8'h00); wr(A_CLO, 8'h00);
         wr(A_DHI, 8'(nh)); wr(A_DLO, 8'(nl));
         wr(A_CHI, ctl_byte(1'b1, 3, 1'b0, 1'b1));
         wr(A_CLO, ctl_byte(1'b1, 0, 1'b0, 1'b1));
         t0 = cyc;
         wait_irq(1'b1, d);
         check("R11 random joined interval", d, period(nh * 256 + nl, 0));
         check("R11 random low irq quiet", int'(irq_lo), 0);
      end
      wr(A_CHI, 8'h00); wr(A_CLO, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule